// File: doc/BRIEF.md
# SPI Status and Interrupt Unit

This unit gathers the condition flags of an SPI controller and turns them into one interrupt request. The shift engine reports whether a transfer is in flight and when one has finished. The two FIFOs report their occupancy counts, and the engine signals each pop from the transmit FIFO and each push into the receive FIFO. From these inputs the unit derives six events: transfer pending, transfer done, transmit level at or below its threshold, receive level at or above its threshold, transmit underflow and receive overflow. Each event sets a sticky status bit. Software clears a status bit by writing a one to it.

A small register port lets software reach four registers: the status register, the interrupt-enable register, the threshold register and a read-only word-count register. The enable bits use their own bit order, which differs from the status bit order. The interrupt line is the OR of every enabled sticky bit. The pending bit is reported in status but never raises the interrupt. When the receive FIFO is full, the unit refuses the incoming word and flags the overflow.

Top module: `spi_irq_unit`

## Requirements
- R1: After reset, status reads 0x00, enable reads 0x00, the threshold register reads 0xF0 and `irq` is low.
- R2: Status bit positions are: bit 0 pending (`xfer_busy` high), bit 1 done (`xfer_done`), bit 2 transmit threshold, bit 3 receive threshold, bit 4 transmit underflow and bit 5 receive overflow. A bit sets on the clock edge where its event is present and then stays set after the event goes away.
- R3: A write to the status register (address 0) clears exactly the bits written as one. Bits written as zero keep their value.
- R4: If an event and a write-one-to-clear of its bit fall in the same cycle, the bit stays set.
- R5: The threshold register (address 2) holds the transmit threshold in bits [3:0] and the receive threshold in bits [7:4]. The transmit-threshold event is present while `tx_count` is at or below its threshold. The receive-threshold event is present while `rx_count` is at or above its threshold.
- R6: A pop request on `tx_pop` while `tx_count` is 0 sets status bit 4. A pop while the count is nonzero does not set it.
- R7: A push on `rx_push` while `rx_count` equals DEPTH (8) drives `rx_accept` low in that cycle and sets status bit 5. Otherwise a push is accepted and bit 5 is not set.
- R8: The enable register (address 1) uses this layout: bit 0 done, bit 1 transmit threshold, bit 2 receive threshold, bit 3 underflow, bit 4 overflow. Only these bits can be written. `irq` is high exactly when some enabled event has its status bit set. The pending bit never raises `irq`.
- R9: The word-count register (address 3) returns the live `rx_count` in bits [3:0] and `tx_count` in bits [7:4]. All other bits read zero.
- R10: Addresses other than 0 to 3 read as zero, and writes to them change no register. Status bits 31:6 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from reg_addr) |
| xfer_busy | input | 1 | Shift engine has a transfer in flight |
| xfer_done | input | 1 | Transfer completion pulse |
| tx_pop | input | 1 | Engine requests a word from the transmit FIFO |
| rx_push | input | 1 | Engine delivers a received word |
| tx_count | input | 4 | Transmit FIFO occupancy |
| rx_count | input | 4 | Receive FIFO occupancy |
| rx_accept | output | 1 | Received word may be stored (low drops it) |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the same-cycle race between an event and its clear. A design that let the clear win would lose a done or overflow event that software never saw. It also drives the enable-to-status bit mapping with one event at a time. A design that applied enable bit i to status bit i would raise `irq` on the wrong event, and it would also let pending interrupt. Both threshold comparisons are driven exactly at their equality points, where a strict comparison would miss the event. The full-FIFO push is checked for its drop signal, and the count-zero pop for its underflow flag.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int ST_W = 6;
    localparam int EN_W = 5;

    localparam int ST_PEND   = 0;
    localparam int ST_DONE   = 1;
    localparam int ST_TXLVL  = 2;
    localparam int ST_RXLVL  = 3;
    localparam int ST_TXUND  = 4;
    localparam int ST_RXOVF  = 5;

    localparam int ADDR_STATUS = 0;
    localparam int ADDR_ENABLE = 1;
    localparam int ADDR_THRESH = 2;
    localparam int ADDR_COUNT  = 3;

    typedef struct packed {
        logic [ST_W-1:0] bits;
    } status_state_t;

endpackage

// File: rtl/spi_irq_events.sv
module spi_irq_events
    import spi_irq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             xfer_busy,
    input  logic             xfer_done,
    input  logic             tx_pop,
    input  logic             rx_push,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_thr,
    input  logic [CNT_W-1:0] rx_thr,
    output logic [ST_W-1:0]  events,
    output logic             rx_accept
);

    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    logic tx_empty;
    logic rx_full;

    always_comb begin
        tx_empty = (tx_count == '0);
        rx_full  = (rx_count >= FULL_LVL);

        events           = '0;
        events[ST_PEND]  = xfer_busy;
        events[ST_DONE]  = xfer_done;
        events[ST_TXLVL] = (tx_count <= tx_thr);
        events[ST_RXLVL] = (rx_count >= rx_thr);
        events[ST_TXUND] = tx_pop & tx_empty;
        events[ST_RXOVF] = rx_push & rx_full;

        rx_accept = rx_push & ~rx_full;
    end

endmodule

// File: rtl/spi_irq_status_reg.sv
module spi_irq_status_reg
    import spi_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] events,
    input  logic            clr_we,
    input  logic [ST_W-1:0] clr_mask,
    output logic [ST_W-1:0] status_q
);

    status_state_t state_d;
    status_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (clr_we) begin
            state_d.bits = state_d.bits & ~clr_mask;
        end
        // setting after clearing lets a same-cycle event survive
        state_d.bits = state_d.bits | events;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign status_q = state_q.bits;

endmodule

// File: rtl/spi_irq_cfg.sv
module spi_irq_cfg
    import spi_irq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_we,
    input  logic [EN_W-1:0]  en_wdata,
    input  logic             thr_we,
    input  logic [CNT_W-1:0] tx_thr_wdata,
    input  logic [CNT_W-1:0] rx_thr_wdata,
    output logic [EN_W-1:0]  en_q,
    output logic [CNT_W-1:0] tx_thr_q,
    output logic [CNT_W-1:0] rx_thr_q
);

    typedef struct packed {
        logic [EN_W-1:0]  en;
        logic [CNT_W-1:0] tx_thr;
        logic [CNT_W-1:0] rx_thr;
    } cfg_state_t;

    cfg_state_t cfg_d;
    cfg_state_t cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (en_we) begin
            cfg_d.en = en_wdata;
        end
        if (thr_we) begin
            cfg_d.tx_thr = tx_thr_wdata;
            cfg_d.rx_thr = rx_thr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.en     <= '0;
            cfg_q.tx_thr <= '0;
            cfg_q.rx_thr <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en_q     = cfg_q.en;
    assign tx_thr_q = cfg_q.tx_thr;
    assign rx_thr_q = cfg_q.rx_thr;

endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
    import spi_irq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              xfer_busy,
    input  logic              xfer_done,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_count,
    output logic              rx_accept,
    output logic              irq
);

    localparam int PAIR_W = 2 * CNT_W;

    logic             sel_status;
    logic             sel_enable;
    logic             sel_thresh;
    logic             sel_count;
    logic [ST_W-1:0]  events;
    logic [ST_W-1:0]  status_q;
    logic [EN_W-1:0]  en_q;
    logic [CNT_W-1:0] tx_thr_q;
    logic [CNT_W-1:0] rx_thr_q;
    logic [EN_W-1:0]  irq_vec;
    logic             unused_wdata;

    assign sel_status = (reg_addr == ADDR_W'(ADDR_STATUS));
    assign sel_enable = (reg_addr == ADDR_W'(ADDR_ENABLE));
    assign sel_thresh = (reg_addr == ADDR_W'(ADDR_THRESH));
    assign sel_count  = (reg_addr == ADDR_W'(ADDR_COUNT));
    assign unused_wdata = ^reg_wdata[DATA_W-1:PAIR_W];

    spi_irq_events #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_events (
        .xfer_busy (xfer_busy),
        .xfer_done (xfer_done),
        .tx_pop    (tx_pop),
        .rx_push   (rx_push),
        .tx_count  (tx_count),
        .rx_count  (rx_count),
        .tx_thr    (tx_thr_q),
        .rx_thr    (rx_thr_q),
        .events    (events),
        .rx_accept (rx_accept)
    );

    spi_irq_status_reg u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .events   (events),
        .clr_we   (reg_wr & sel_status),
        .clr_mask (reg_wdata[ST_W-1:0]),
        .status_q (status_q)
    );

    spi_irq_cfg #(
        .CNT_W (CNT_W)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_we        (reg_wr & sel_enable),
        .en_wdata     (reg_wdata[EN_W-1:0]),
        .thr_we       (reg_wr & sel_thresh),
        .tx_thr_wdata (reg_wdata[CNT_W-1:0]),
        .rx_thr_wdata (reg_wdata[PAIR_W-1:CNT_W]),
        .en_q         (en_q),
        .tx_thr_q     (tx_thr_q),
        .rx_thr_q     (rx_thr_q)
    );

    // enable bit i gates status bit i+1; pending (status bit 0) has no enable
    for (genvar i = 0; i < EN_W; i++) begin : g_irq_map
        assign irq_vec[i] = en_q[i] & status_q[i+1];
    end

    assign irq = |irq_vec;

    always_comb begin
        reg_rdata = '0;
        if (sel_status) begin
            reg_rdata[ST_W-1:0] = status_q;
        end else if (sel_enable) begin
            reg_rdata[EN_W-1:0] = en_q;
        end else if (sel_thresh) begin
            reg_rdata[PAIR_W-1:0] = {rx_thr_q, tx_thr_q};
        end else if (sel_count) begin
            reg_rdata[PAIR_W-1:0] = {tx_count, rx_count};
        end
    end

endmodule

// File: rtl/spi_irq_checker.sv
module spi_irq_checker
    import spi_irq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              xfer_done,
    input logic              tx_pop,
    input logic              rx_push,
    input logic [CNT_W-1:0]  tx_count,
    input logic [CNT_W-1:0]  rx_count,
    input logic              rx_accept,
    input logic              irq,
    input logic [ST_W-1:0]   st
);

    logic [ST_W-1:0] clr_w;
    logic [ST_W-1:0] keep;
    logic            full_push;

    assign clr_w     = (reg_wr && reg_addr == ADDR_W'(ADDR_STATUS)) ? reg_wdata[ST_W-1:0] : '0;
    assign keep      = st & ~clr_w;
    assign full_push = rx_push && (rx_count == CNT_W'(DEPTH));

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (keep != '0) |=> ((st & $past(keep)) == $past(keep)));

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w[ST_RXOVF] && !full_push) |=> !st[ST_RXOVF]);

    assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> st[ST_DONE]);

    assert_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && tx_count == '0) |=> st[ST_TXUND]);

    assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        full_push |-> !rx_accept);

    assert_pending_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st[ST_W-1:1] == '0) |-> !irq);

    assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(ADDR_STATUS)) |-> (reg_rdata[DATA_W-1:ST_W] == '0));

endmodule

bind spi_irq_unit spi_irq_checker #(
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .xfer_done (xfer_done),
    .tx_pop    (tx_pop),
    .rx_push   (rx_push),
    .tx_count  (tx_count),
    .rx_count  (rx_count),
    .rx_accept (rx_accept),
    .irq       (irq),
    .st        (status_q)
);

// File: tb/sim_spi_irq_unit.sv
module sim_spi_irq_unit;

    localparam int CLK_P = 10;
    localparam int WD_CYCLES = 20000;

    typedef struct packed {
        logic [3:0] tx;
        logic [3:0] rx;
        logic [3:0] ttx;
        logic [3:0] trx;
        logic [5:0] exp;
    } vec_t;

    // threshold vectors at and around the equality points (R5)
    localparam vec_t VECS [0:5] = '{
        '{4'd3, 4'd2, 4'd3, 4'd5, 6'h04},
        '{4'd4, 4'd5, 4'd3, 4'd5, 6'h08},
        '{4'd0, 4'd8, 4'd0, 4'd8, 6'h0C},
        '{4'd8, 4'd7, 4'd7, 4'd8, 6'h00},
        '{4'd2, 4'd0, 4'd6, 4'd0, 6'h0C},
        '{4'd8, 4'd8, 4'd15, 4'd15, 6'h04}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xfer_busy = 1'b0;
    logic        xfer_done = 1'b0;
    logic        tx_pop = 1'b0;
    logic        rx_push = 1'b0;
    logic [3:0]  tx_count = 4'd5;
    logic [3:0]  rx_count = 4'd0;
    logic        rx_accept;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] rd_v;

    always #(CLK_P/2) clk = ~clk;

    spi_irq_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .xfer_busy (xfer_busy),
        .xfer_done (xfer_done),
        .tx_pop    (tx_pop),
        .rx_push   (rx_push),
        .tx_count  (tx_count),
        .rx_count  (rx_count),
        .rx_accept (rx_accept),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        rd(3'd0, rd_v); chk("R1 status", rd_v, 32'h0);
        rd(3'd1, rd_v); chk("R1 enable", rd_v, 32'h0);
        rd(3'd2, rd_v); chk("R1 threshold", rd_v, 32'hF0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        @(negedge clk);

        // R5: vector table walk
        for (int i = 0; i < 6; i++) begin
            tx_count = VECS[i].tx;
            rx_count = VECS[i].rx;
            wr(3'd2, {24'b0, VECS[i].trx, VECS[i].ttx});
            wr(3'd0, 32'h3F);
            rd(3'd0, rd_v);
            chk($sformatf("R5 vector %0d", i), rd_v, {26'b0, VECS[i].exp});
        end

        // neutral state
        tx_count = 4'd5;
        rx_count = 4'd0;
        wr(3'd2, 32'hF0);
        wr(3'd0, 32'h3F);
        rd(3'd0, rd_v); chk("R3 clear all", rd_v, 32'h0);

        // R9: word count layout
        tx_count = 4'd6;
        rx_count = 4'd3;
        rd(3'd3, rd_v); chk("R9 word count", rd_v, 32'h63);
        tx_count = 4'd5;
        rx_count = 4'd0;
        @(negedge clk);

        // R2: done is sticky
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        rd(3'd0, rd_v); chk("R2 done set", rd_v, 32'h02);
        repeat (3) @(negedge clk);
        rd(3'd0, rd_v); chk("R2 done sticky", rd_v, 32'h02);

        // R6: pop with data, then pop on empty
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
        rd(3'd0, rd_v); chk("R6 pop nonempty", rd_v, 32'h02);
        tx_count = 4'd0;
        wr(3'd2, 32'hF0);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
        tx_count = 4'd5;
        rd(3'd0, rd_v); chk("R6 underflow bit4", rd_v & 32'h10, 32'h10);

        // R3: selective clear (status now bits 1,2,4)
        wr(3'd0, 32'h04);
        wr(3'd0, 32'h00);
        rd(3'd0, rd_v); chk("R3 zero write keeps", rd_v, 32'h12);
        wr(3'd0, 32'h02);
        rd(3'd0, rd_v); chk("R3 clear done only", rd_v, 32'h10);

        // R4: event beats clear in the same cycle
        xfer_done = 1'b1;
        wr(3'd0, 32'h12);
        xfer_done = 1'b0;
        rd(3'd0, rd_v); chk("R4 event wins", rd_v, 32'h02);
        wr(3'd0, 32'h3F);

        // R7: push into full and not full
        rx_count = 4'd8;
        rx_push = 1'b1;
        #1;
        chk("R7 full drops", {31'b0, rx_accept}, 32'h0);
        @(negedge clk);
        rx_count = 4'd7;
        #1;
        chk("R7 accept", {31'b0, rx_accept}, 32'h1);
        rd(3'd0, rd_v); chk("R7 overflow bit5", rd_v, 32'h20);
        wr(3'd0, 32'h3F);
        rx_push = 1'b0;
        rd(3'd0, rd_v); chk("R7 no overflow when room", rd_v, 32'h0);
        rx_count = 4'd0;

        // R8: enable layout and irq
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, rd_v); chk("R8 enable width", rd_v, 32'h1F);
        xfer_busy = 1'b1;
        @(negedge clk);
        xfer_busy = 1'b0;
        rd(3'd0, rd_v); chk("R8 pending set", rd_v, 32'h01);
        chk("R8 pending quiet", {31'b0, irq}, 32'h0);
        wr(3'd0, 32'h3F);
        wr(3'd1, 32'h04);
        tx_count = 4'd0;
        @(negedge clk);
        tx_count = 4'd5;
        chk("R8 tx level not enabled", {31'b0, irq}, 32'h0);
        wr(3'd2, 32'h00);
        wr(3'd2, 32'hF0);
        chk("R8 rx level enabled", {31'b0, irq}, 32'h1);
        wr(3'd0, 32'h3F);
        chk("R8 irq drops on clear", {31'b0, irq}, 32'h0);
        wr(3'd1, 32'h01);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk("R8 done enabled", {31'b0, irq}, 32'h1);

        // R10: unused address
        rd(3'd5, rd_v); chk("R10 unused reads zero", rd_v, 32'h0);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd0, rd_v); chk("R10 status untouched", rd_v, 32'h02);
        rd(3'd1, rd_v); chk("R10 enable untouched", rd_v, 32'h01);
        rd(3'd2, rd_v); chk("R10 threshold untouched", rd_v, 32'hF0);

        finish_run();
    end

endmodule